// File: doc/BRIEF.md
# Transmit End-of-Message Controller

This block is the end-of-message control for the transmit side of a synchronous serial channel. It owns a single end-of-message latch. Software arms the latch through a register write, and hardware sets it again when the closing sequence of a frame begins. While the latch is armed and the transmit buffer runs dry, the block asks the serializer to close the frame. In bit-oriented framing with abort-on-underrun selected it sends an abort followed by a flag. In every other case it appends the CRC.

Register writes arrive as a strobe carrying two fields. The first is a 2-bit CRC field that resets the transmit CRC generator, resets the receive CRC checker, or arms the latch. The second is a 3-bit operation field that clears the pending status event, requests a software abort, or holds off the transmit interrupt. The block also raises a one-cycle status-change event and a level transmit interrupt request. The serializer and the CRC arithmetic are outside this block.

Top module: `tx_eom_ctrl`

## Requirements
- R1: After reset, eomLatch is 1. sendCrc, sendAbort, sendFlag, statusEvent, flushBuf, crcGenReset and rxCrcReset are all 0.
- R2: The crcCmd field is qualified by cmdWr and acts in the cycle after the write. Value 2'b10 pulses crcGenReset and value 2'b01 pulses rxCrcReset, each for one cycle. Value 2'b00 has no effect. The operation codes 3'b001, 3'b100 and 3'b111 have no effect.
- R3: A write with crcCmd 2'b11 while txEnable is 1 clears eomLatch in the next cycle.
- R4: Underrun is txEnable, bufEmpty and a cleared latch, all while idle. Outside abort-on-underrun framing, an underrun sets the latch and raises sendCrc from the next cycle until the cycle after crcDone.
- R5: With sdlcMode and abortOnUnderrun both 1, an underrun sets the latch. sendAbort is then held for exactly 8 bitEn pulses, then sendFlag for exactly 8 bitEn pulses, and the block returns to idle. Cycles without bitEn do not advance either count.
- R6: A write with crcCmd 2'b11 while txEnable is 0 leaves the internal latch set, so a later underrun sends nothing. eomLatch still reads 0 afterwards. statusEvent pulses if no status event is pending, or if the same write carries operation code 3'b010.
- R7: statusEvent pulses for one cycle after a change of the latch, unless a status event is already pending. Each pulse makes one pending. Operation code 3'b010 clears the pending state.
- R8: Operation code 3'b011 pulses flushBuf and sets the latch in the next cycle. If sdlcMode and txEnable are both 1, it also holds sendAbort for exactly 8 bitEn pulses and then returns to idle with no flag. A set and a clear in the same write leave the latch set.
- R9: txIrq equals txIntEnable AND bufEmpty AND NOT held. Operation code 3'b101 sets the hold. A bufLoad or crcDone pulse releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWr | input | 1 | Register write strobe qualifying crcCmd and cmdCode |
| crcCmd | input | 2 | CRC command field |
| cmdCode | input | 3 | Operation command field |
| txEnable | input | 1 | Transmitter enabled |
| sdlcMode | input | 1 | Bit-oriented framing selected |
| abortOnUnderrun | input | 1 | Close frame with abort and flag on underrun |
| bufEmpty | input | 1 | Transmit buffer empty |
| bufLoad | input | 1 | A character was loaded into the buffer |
| crcDone | input | 1 | Serializer finished sending the CRC |
| bitEn | input | 1 | Bit-time enable from the serializer |
| txIntEnable | input | 1 | Transmit interrupt enable |
| sendCrc | output | 1 | Request to append CRC |
| sendAbort | output | 1 | Request to send ones (abort) |
| sendFlag | output | 1 | Request to send a flag |
| eomLatch | output | 1 | Latch status bit as software sees it |
| statusEvent | output | 1 | One-cycle status-change event |
| txIrq | output | 1 | Transmit interrupt request |
| flushBuf | output | 1 | One-cycle transmit buffer flush |
| crcGenReset | output | 1 | One-cycle transmit CRC generator reset |
| rxCrcReset | output | 1 | One-cycle receive CRC checker reset |

## Verification
The bench counts bitEn pulses across the abort and flag phases and leaves idle cycles between them. A counter off by one, or one that runs on every clock, shows up as a sequence that is too long or too short. It arms the latch while the transmitter is disabled and then forces an underrun. A design that lets that write reach the latch would send a CRC, and one that drops the status side effect would show no event or a stale status bit. It also sends a set and a clear in one write, and raises events while one is still pending. Wrong priority then leaves the latch armed, and missing queueing produces extra events. Finally it checks that both bufLoad and crcDone release the interrupt hold.

// File: rtl/tx_eom_pkg.sv
package tx_eom_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_CRC, ST_ABORT, ST_FLAG} eomState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic setLatch;
    logic clrLatch;
    logic showClear;
    logic rstStatus;
    logic holdInt;
    logic flush;
    logic genRst;
    logic rxRst;
    logic cntClr;
    logic cntInc;
  } eomStrobes_t;

  localparam logic [1:0] CRC_RX_RST  = 2'b01;
  localparam logic [1:0] CRC_GEN_RST = 2'b10;
  localparam logic [1:0] CRC_ARM     = 2'b11;
  localparam logic [2:0] OP_RST_STATUS = 3'b010;
  localparam logic [2:0] OP_ABORT      = 3'b011;
  localparam logic [2:0] OP_HOLD_INT   = 3'b101;
endpackage

// File: rtl/tx_eom_ctl.sv
module tx_eom_ctl
  import tx_eom_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdWr,
  input  logic [1:0]  crcCmd,
  input  logic [2:0]  cmdCode,
  input  logic        txEnable,
  input  logic        sdlcMode,
  input  logic        abortOnUnderrun,
  input  logic        bufEmpty,
  input  logic        crcDone,
  input  logic        bitEn,
  input  logic        latchQ,
  input  logic        cntLast,
  output eomState_t   stateQ,
  output eomStrobes_t strb
);
  eomState_t nextState;
  logic flagAfter, nextFlag;
  logic [1:0] crcWr;
  logic opAbort;

  always_comb begin
    strb      = '0;
    nextState = stateQ;
    nextFlag  = flagAfter;
    crcWr     = cmdWr ? crcCmd : 2'b00;
    opAbort   = cmdWr && (cmdCode == OP_ABORT);

    strb.genRst    = (crcWr == CRC_GEN_RST);
    strb.rxRst     = (crcWr == CRC_RX_RST);
    strb.clrLatch  = (crcWr == CRC_ARM) && txEnable;
    strb.showClear = (crcWr == CRC_ARM) && !txEnable;
    strb.rstStatus = cmdWr && (cmdCode == OP_RST_STATUS);
    strb.holdInt   = cmdWr && (cmdCode == OP_HOLD_INT);
    strb.flush     = opAbort;

    unique case (stateQ)
      ST_IDLE: begin
        if (txEnable && bufEmpty && !latchQ) begin
          strb.setLatch = 1'b1;
          strb.cntClr   = 1'b1;
          if (sdlcMode && abortOnUnderrun) begin
            nextState = ST_ABORT;
            nextFlag  = 1'b1;
          end else begin
            nextState = ST_CRC;
          end
        end
      end
      ST_CRC: if (crcDone) nextState = ST_IDLE;
      ST_ABORT: begin
        if (bitEn) begin
          if (cntLast) begin
            strb.cntClr = 1'b1;
            nextState   = flagAfter ? ST_FLAG : ST_IDLE;
          end else begin
            strb.cntInc = 1'b1;
          end
        end
      end
      ST_FLAG: begin
        if (bitEn) begin
          if (cntLast) begin
            strb.cntClr = 1'b1;
            nextState   = ST_IDLE;
          end else begin
            strb.cntInc = 1'b1;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase

    if (!txEnable) nextState = ST_IDLE;

    // Software abort overrides any sequence in progress
    if (opAbort) begin
      strb.setLatch = 1'b1;
      if (sdlcMode && txEnable) begin
        nextState   = ST_ABORT;
        nextFlag    = 1'b0;
        strb.cntClr = 1'b1;
        strb.cntInc = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      flagAfter <= 1'b0;
    end else begin
      stateQ    <= nextState;
      flagAfter <= nextFlag;
    end
  end
endmodule

// File: rtl/tx_eom_dp.sv
module tx_eom_dp
  import tx_eom_pkg::*;
#(
  parameter int SEQ_LEN = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  eomStrobes_t strb,
  input  logic        bufLoad,
  input  logic        crcDone,
  input  logic        bufEmpty,
  input  logic        txIntEnable,
  output logic        latchQ,
  output logic        cntLast,
  output logic        eomStatus,
  output logic        statusEvent,
  output logic        txIrq,
  output logic        flushBuf,
  output logic        crcGenReset,
  output logic        rxCrcReset
);
  localparam int CNT_W = (SEQ_LEN > 2) ? $clog2(SEQ_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SEQ_LEN - 1);

  logic [CNT_W-1:0] cnt;
  logic latchNext, cause, fire, statPending, intHold;

  always_comb begin
    latchNext = strb.setLatch ? 1'b1 : (strb.clrLatch ? 1'b0 : latchQ);
    cause     = (latchNext != latchQ) || strb.showClear;
    fire      = cause && (!statPending || strb.rstStatus);
  end

  assign cntLast = (cnt == CNT_LAST);
  assign txIrq   = txIntEnable && bufEmpty && !intHold;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchQ      <= 1'b1;
      eomStatus   <= 1'b1;
      statPending <= 1'b0;
      statusEvent <= 1'b0;
      intHold     <= 1'b0;
      cnt         <= '0;
      flushBuf    <= 1'b0;
      crcGenReset <= 1'b0;
      rxCrcReset  <= 1'b0;
    end else begin
      latchQ      <= latchNext;
      eomStatus   <= strb.setLatch | (eomStatus & ~(strb.clrLatch | strb.showClear));
      statusEvent <= fire;
      statPending <= fire | (statPending & ~strb.rstStatus);
      intHold     <= strb.holdInt | (intHold & ~(bufLoad | crcDone));
      if (strb.cntClr)      cnt <= '0;
      else if (strb.cntInc) cnt <= cnt + CNT_W'(1);
      flushBuf    <= strb.flush;
      crcGenReset <= strb.genRst;
      rxCrcReset  <= strb.rxRst;
    end
  end
endmodule

// File: rtl/tx_eom_ctrl.sv
module tx_eom_ctrl
  import tx_eom_pkg::*;
#(
  parameter int SEQ_LEN = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdWr,
  input  logic [1:0] crcCmd,
  input  logic [2:0] cmdCode,
  input  logic       txEnable,
  input  logic       sdlcMode,
  input  logic       abortOnUnderrun,
  input  logic       bufEmpty,
  input  logic       bufLoad,
  input  logic       crcDone,
  input  logic       bitEn,
  input  logic       txIntEnable,
  output logic       sendCrc,
  output logic       sendAbort,
  output logic       sendFlag,
  output logic       eomLatch,
  output logic       statusEvent,
  output logic       txIrq,
  output logic       flushBuf,
  output logic       crcGenReset,
  output logic       rxCrcReset
);
  eomState_t   stateQ;
  eomStrobes_t strb;
  logic latchQ, cntLast;

  tx_eom_ctl u_ctl (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .crcCmd(crcCmd), .cmdCode(cmdCode),
    .txEnable(txEnable), .sdlcMode(sdlcMode), .abortOnUnderrun(abortOnUnderrun),
    .bufEmpty(bufEmpty), .crcDone(crcDone), .bitEn(bitEn),
    .latchQ(latchQ), .cntLast(cntLast), .stateQ(stateQ), .strb(strb)
  );

  tx_eom_dp #(.SEQ_LEN(SEQ_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .bufLoad(bufLoad), .crcDone(crcDone),
    .bufEmpty(bufEmpty), .txIntEnable(txIntEnable), .latchQ(latchQ),
    .cntLast(cntLast), .eomStatus(eomLatch), .statusEvent(statusEvent),
    .txIrq(txIrq), .flushBuf(flushBuf), .crcGenReset(crcGenReset),
    .rxCrcReset(rxCrcReset)
  );

  assign sendCrc   = (stateQ == ST_CRC);
  assign sendAbort = (stateQ == ST_ABORT);
  assign sendFlag  = (stateQ == ST_FLAG);
endmodule

// File: rtl/tx_eom_chk.sv
module tx_eom_chk #(
  parameter int SEQ_LEN = 8
) (
  input logic       clk,
  input logic       rstN,
  input logic       cmdWr,
  input logic [1:0] crcCmd,
  input logic [2:0] cmdCode,
  input logic       txEnable,
  input logic       sdlcMode,
  input logic       bufEmpty,
  input logic       bitEn,
  input logic       txIntEnable,
  input logic       sendCrc,
  input logic       sendAbort,
  input logic       sendFlag,
  input logic       eomLatch,
  input logic       txIrq,
  input logic       flushBuf,
  input logic       crcGenReset
);
  localparam int AW = $clog2(SEQ_LEN + 1) + 1;
  logic [AW-1:0] abortCnt;

  // Bit enables seen during the current abort run
  always_ff @(posedge clk) begin
    if (!rstN) abortCnt <= '0;
    else if (cmdWr && cmdCode == 3'b011 && sdlcMode && txEnable) abortCnt <= '0;
    else if (!sendAbort) abortCnt <= '0;
    else if (bitEn) abortCnt <= abortCnt + AW'(1);
  end

  p_one_request_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sendCrc, sendAbort, sendFlag}));

  p_abort_len_r5: assert property (@(posedge clk) disable iff (!rstN)
    sendAbort |-> (abortCnt < AW'(SEQ_LEN)));

  p_flag_after_abort_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sendFlag) |-> $past(sendAbort));

  p_crc_sets_latch_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sendCrc) |-> eomLatch);

  p_gen_reset_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && crcCmd == 2'b10) |=> crcGenReset);

  p_abort_cmd_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && cmdCode == 3'b011) |=> (flushBuf && eomLatch));

  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    txIrq |-> (txIntEnable && bufEmpty));
endmodule

bind tx_eom_ctrl tx_eom_chk #(.SEQ_LEN(SEQ_LEN)) u_chk (
  .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .crcCmd(crcCmd), .cmdCode(cmdCode),
  .txEnable(txEnable), .sdlcMode(sdlcMode), .bufEmpty(bufEmpty), .bitEn(bitEn),
  .txIntEnable(txIntEnable), .sendCrc(sendCrc), .sendAbort(sendAbort),
  .sendFlag(sendFlag), .eomLatch(eomLatch), .txIrq(txIrq), .flushBuf(flushBuf),
  .crcGenReset(crcGenReset)
);

// File: tb/tx_eom_ctrl_bench.sv
`timescale 1ns/1ps
module tx_eom_ctrl_bench;
  logic clk = 1'b0, rstN = 1'b0;
  logic cmdWr = 0, txEnable = 0, sdlcMode = 0, abortOnUnderrun = 0;
  logic bufEmpty = 0, bufLoad = 0, crcDone = 0, bitEn = 0, txIntEnable = 0;
  logic [1:0] crcCmd = 0;
  logic [2:0] cmdCode = 0;
  logic sendCrc, sendAbort, sendFlag, eomLatch, statusEvent, txIrq;
  logic flushBuf, crcGenReset, rxCrcReset;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tx_eom_ctrl u_tx_eom_ctrl (.*);

  // {crcCmd, cmdCode, txIntEnable, bufEmpty, expGen, expRx, expIrq}
  localparam logic [9:0] VEC [8] = '{
    10'b00_000_0_0_000, 10'b01_000_1_1_011, 10'b10_000_1_0_100,
    10'b11_000_0_1_000, 10'b10_010_1_1_101, 10'b01_111_0_1_010,
    10'b00_100_1_1_001, 10'b10_001_1_1_101 };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string tag, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] c, logic [2:0] op);
    crcCmd = c; cmdCode = op; cmdWr = 1'b1;
    tick();
    cmdWr = 1'b0; crcCmd = 2'b00; cmdCode = 3'b000;
  endtask

  task automatic finish();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      finish();
    end
  end

  initial begin
    tick(); tick();
    rstN = 1'b1;
    tick();
    // R1 reset state
    chk("R1 eomLatch", eomLatch, 1'b1);
    chk("R1 sends", sendCrc | sendAbort | sendFlag, 1'b0);
    chk("R1 pulses", statusEvent | flushBuf | crcGenReset | rxCrcReset, 1'b0);

    // R2/R9 vector table, transmitter disabled
    foreach (VEC[i]) begin
      txIntEnable = VEC[i][4]; bufEmpty = VEC[i][3];
      wr(VEC[i][9:8], VEC[i][7:5]);
      chk($sformatf("R2 gen vec%0d", i), crcGenReset, VEC[i][2]);
      chk($sformatf("R2 rx vec%0d", i), rxCrcReset, VEC[i][1]);
      chk($sformatf("R9 irq vec%0d", i), txIrq, VEC[i][0]);
    end
    txIntEnable = 0; bufEmpty = 0;

    // R3 arm with transmitter enabled, R7 event
    txEnable = 1;
    wr(2'b11, 3'b000);
    chk("R3 latch cleared", eomLatch, 1'b0);
    chk("R7 event on change", statusEvent, 1'b1);

    // R4 underrun appends CRC
    bufEmpty = 1; tick(); bufEmpty = 0;
    chk("R4 sendCrc", sendCrc, 1'b1);
    chk("R4 latch set", eomLatch, 1'b1);
    chk("R7 event held while pending", statusEvent, 1'b0);
    tick(); tick();
    chk("R4 crc held", sendCrc, 1'b1);
    crcDone = 1; tick(); crcDone = 0;
    chk("R4 crc ends", sendCrc, 1'b0);

    // R5 abort then flag on underrun
    wr(2'b00, 3'b010);
    sdlcMode = 1; abortOnUnderrun = 1;
    wr(2'b11, 3'b000);
    chk("R7 event after clear", statusEvent, 1'b1);
    bufEmpty = 1; tick(); bufEmpty = 0;
    chk("R5 latch set", eomLatch, 1'b1);
    chk("R5 sendCrc", sendCrc, 1'b0);
    for (int i = 0; i < 8; i++) begin
      chk($sformatf("R5 abort bit%0d", i), sendAbort, 1'b1);
      bitEn = 1; tick(); bitEn = 0;
      if (i == 3) begin tick(); tick(); end
    end
    chk("R5 abort ends", sendAbort, 1'b0);
    chk("R5 flag starts", sendFlag, 1'b1);
    for (int i = 0; i < 8; i++) begin
      chk($sformatf("R5 flag bit%0d", i), sendFlag, 1'b1);
      bitEn = 1; tick(); bitEn = 0;
    end
    chk("R5 flag ends", sendFlag, 1'b0);

    // R8 software abort: eight ones, no flag
    wr(2'b00, 3'b011);
    chk("R8 flush", flushBuf, 1'b1);
    chk("R8 abort", sendAbort, 1'b1);
    for (int i = 0; i < 8; i++) begin
      bitEn = 1; tick(); bitEn = 0;
    end
    chk("R8 abort ends", sendAbort, 1'b0);
    chk("R8 no flag", sendFlag, 1'b0);

    // R6 arm while disabled
    wr(2'b00, 3'b010);
    txEnable = 0; tick();
    wr(2'b11, 3'b000);
    chk("R6 shown reset", eomLatch, 1'b0);
    chk("R6 event", statusEvent, 1'b1);
    txEnable = 1; bufEmpty = 1; tick(); tick(); bufEmpty = 0;
    chk("R6 no crc", sendCrc, 1'b0);
    chk("R6 no abort", sendAbort, 1'b0);
    txEnable = 0;
    wr(2'b11, 3'b000);
    chk("R6 pending blocks", statusEvent, 1'b0);
    wr(2'b11, 3'b010);
    chk("R6 with status reset", statusEvent, 1'b1);

    // R8 set wins over clear
    txEnable = 1; sdlcMode = 0; abortOnUnderrun = 0;
    wr(2'b11, 3'b011);
    chk("R8 set wins", eomLatch, 1'b1);
    chk("R8 flush2", flushBuf, 1'b1);
    chk("R8 no abort outside sdlc", sendAbort, 1'b0);
    bufEmpty = 1; tick();
    chk("R8 latch armed not", sendCrc, 1'b0);

    // R9 interrupt hold
    txIntEnable = 1; tick();
    chk("R9 irq", txIrq, 1'b1);
    wr(2'b00, 3'b101);
    chk("R9 held", txIrq, 1'b0);
    tick();
    chk("R9 still held", txIrq, 1'b0);
    bufLoad = 1; tick(); bufLoad = 0;
    chk("R9 released by load", txIrq, 1'b1);
    wr(2'b00, 3'b101);
    chk("R9 held again", txIrq, 1'b0);
    crcDone = 1; tick(); crcDone = 0;
    chk("R9 released by crcDone", txIrq, 1'b1);

    done = 1;
    finish();
  end
endmodule